// File: doc/BRIEF.md
# TDM Serial Frame Receiver

This block takes a time-division-multiplexed serial line (a bit clock, a frame sync and a data bit) and turns it into a stream of bytes, each tagged with the timeslot it came from. Two frame formats are supported. The 24-channel format has 193 bits: one framing bit and then 192 payload bits. The 32-channel format has 256 bits made of 32 byte slots and no framing bit; at 2.048 MHz it carries 8000 frames per second. The line clock, sync and data are oversampled in the system clock domain. This lets the sync and the data each be taken on either edge of the line clock, chosen separately.

A detected sync arms a programmable delay, counted in data samples, and the frame starts when that delay runs out. Static configuration inputs set the sync polarity, the bit order inside a byte and an optional inversion of the data. In the 24-channel format the framing bit can be delivered as a byte of its own, ahead of the payload, or dropped. Each byte appears on a one-cycle write strobe toward a receive FIFO. A strobe that meets a deasserted ready loses its byte and latches an overflow flag. A sync that arrives away from the expected frame start produces an error pulse, and the bit counter realigns to that sync.

Top module: `tdm_frame_rx`

## Requirements
- R1: With `cfg_t1`=1 a frame is 193 line bits. Frame bit 0 is the framing bit, and bits 1..192 form 24 payload bytes tagged with slots 0..23 in arrival order.
- R2: With `cfg_t1`=1 and `cfg_fbit_en`=1, the framing bit is output before slot 0 of the same frame as one byte. That byte has the bit in position 0, zeros in positions 7..1, `out_fbit`=1 and `out_slot`=0. With `cfg_fbit_en`=0 no byte is output for the framing bit. Payload bytes always have `out_fbit`=0.
- R3: With `cfg_t1`=0 a frame is 256 line bits, split into 32 bytes tagged with slots 0..31. There is no framing-bit byte.
- R4: Frame bit 0 is the data sample that has exactly `cfg_offset` earlier data samples between it and the sync detection. A data sample taken in the same system cycle as the sync detection, or later, counts.
- R5: A sync is detected when the sampled sync line goes from inactive to active. The active level is high when `cfg_sync_low`=0 and low when `cfg_sync_low`=1.
- R6: The sync line is sampled on the falling line-clock edge when `cfg_sync_fall`=1 and on the rising edge otherwise. The data line is sampled on the falling edge when `cfg_data_fall`=1 and on the rising edge otherwise. The two selections are independent.
- R7: With `cfg_lsb_first`=0 the first bit of a slot on the line becomes byte bit 7. With `cfg_lsb_first`=1 it becomes byte bit 0.
- R8: With `cfg_invert`=1 every sampled data bit is complemented before use, framing bit included.
- R9: `out_valid` is high for one system cycle per byte. If `out_ready` is low in that cycle the byte is lost and `overflow` goes high and stays high until reset.
- R10: After the first frame start, a frame start at a bit position other than 0 of the running count pulses `resync_err` for one cycle. The count restarts at bit 0 from that start.
- R11: No byte is output before the first frame start after reset, whatever the data line carries.
- R12: During and right after reset, `out_valid`, `overflow` and `resync_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the line bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Line bit clock |
| ser_sync | input | 1 | Line frame sync |
| ser_data | input | 1 | Line data |
| cfg_t1 | input | 1 | 1: 193-bit frames, 0: 256-bit frames |
| cfg_fbit_en | input | 1 | Output the framing bit as its own byte |
| cfg_sync_fall | input | 1 | Sample the sync on the falling line-clock edge |
| cfg_data_fall | input | 1 | Sample the data on the falling line-clock edge |
| cfg_sync_low | input | 1 | Sync is active low |
| cfg_lsb_first | input | 1 | First line bit of a slot goes to byte bit 0 |
| cfg_invert | input | 1 | Complement received data |
| cfg_offset | input | OFS_W | Data samples from sync detection to frame bit 0 |
| out_ready | input | 1 | FIFO can accept a byte |
| out_valid | output | 1 | Byte strobe, one cycle |
| out_data | output | 8 | Received byte |
| out_slot | output | 5 | Timeslot index of the byte |
| out_fbit | output | 1 | Byte carries the framing bit |
| overflow | output | 1 | Sticky: a byte was lost to a low ready |
| resync_err | output | 1 | Pulse: sync found off the expected frame start |

## Verification
The whole receive path is visible at the ports as a sequence of bytes and slot tags. A slip in the bit counter or the offset countdown shows up in the first byte after the frame start: that byte carries shifted bits or the wrong slot number. A mistake in edge selection or polarity shifts the whole stream by one bit or keeps the block from locking at all. Each scenario therefore compares every byte of one or more complete frames against a model built from the bits the bench drove. The error pulse and the sticky flag are checked in the same run that provokes them.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   localparam int BYTE_W = 8;
   localparam int SLOT_W = 5;

   typedef struct packed {
      logic              fbit;
      logic [SLOT_W-1:0] slot;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_clk,
   input  logic line_sync,
   input  logic line_data,
   output logic clk_rise,
   output logic clk_fall,
   output logic sync_q,
   output logic data_q
);
   localparam int LANES = 3;

   if (STAGES < 1) begin : g_bad_stages
      $error("tdm_rx_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][LANES-1:0] chain;
   logic                         clk_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= {line_clk, line_sync, line_data};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= chain[STAGES-1][2];
   end

   assign clk_rise = chain[STAGES-1][2] & ~clk_prev;
   assign clk_fall = ~chain[STAGES-1][2] & clk_prev;
   assign sync_q   = chain[STAGES-1][1];
   assign data_q   = chain[STAGES-1][0];
endmodule

// File: rtl/tdm_rx_align.sv
module tdm_rx_align #(
   parameter int OFS_W  = 8,
   parameter int T1_BITS = 193,
   parameter int E1_BITS = 256,
   localparam int POS_W = $clog2(E1_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_evt,
   input  logic             sync_act,
   input  logic             data_evt,
   input  logic             cfg_t1,
   input  logic [OFS_W-1:0] cfg_offset,
   output logic             bit_ok,
   output logic [POS_W-1:0] bit_pos,
   output logic             resync_err
);
   if (T1_BITS >= E1_BITS) begin : g_bad_len
      $error("tdm_rx_align: T1_BITS must be below E1_BITS");
   end

   logic             prev_act;
   logic             pend;
   logic [OFS_W-1:0] cnt;
   logic             locked;
   logic [POS_W-1:0] bit_idx;

   logic             det, pend_now, start;
   logic [OFS_W-1:0] cnt_now;
   logic [POS_W-1:0] last_pos;

   assign det      = sync_evt & sync_act & ~prev_act;
   assign pend_now = det | pend;
   assign cnt_now  = det ? cfg_offset : cnt;
   assign start    = data_evt & pend_now & (cnt_now == '0);
   assign last_pos = cfg_t1 ? POS_W'(T1_BITS - 1) : POS_W'(E1_BITS - 1);
   assign bit_pos  = start ? '0 : bit_idx;
   assign bit_ok   = data_evt & (locked | start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_act   <= 1'b0;
         pend       <= 1'b0;
         cnt        <= '0;
         locked     <= 1'b0;
         bit_idx    <= '0;
         resync_err <= 1'b0;
      end else begin
         if (sync_evt) prev_act <= sync_act;
         if (data_evt && pend_now) begin
            pend <= (cnt_now != '0);
            cnt  <= (cnt_now != '0) ? cnt_now - 1'b1 : '0;
         end else if (det) begin
            pend <= 1'b1;
            cnt  <= cfg_offset;
         end
         if (bit_ok) begin
            locked  <= 1'b1;
            bit_idx <= (bit_pos == last_pos) ? '0 : bit_pos + 1'b1;
         end
         resync_err <= start & locked & (bit_idx != '0);
      end
   end
endmodule

// File: rtl/tdm_rx_pack.sv
module tdm_rx_pack
   import tdm_rx_pkg::*;
#(
   parameter int POS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_ok,
   input  logic [POS_W-1:0] bit_pos,
   input  logic             bit_val,
   input  logic             cfg_t1,
   input  logic             cfg_fbit_en,
   input  logic             cfg_lsb_first,
   input  logic             out_ready,
   output logic             out_valid,
   output rx_entry_t        out_entry,
   output logic             overflow
);
   localparam int LOW_W = $clog2(BYTE_W);

   if (POS_W < LOW_W + SLOT_W) begin : g_bad_pos
      $error("tdm_rx_pack: POS_W too narrow for slot and bit fields");
   end

   logic [BYTE_W-1:0] shreg, sh_next;
   logic [POS_W-1:0]  dpos;
   logic              is_fbit, emit_fb, emit_d;

   assign is_fbit = cfg_t1 & (bit_pos == '0);
   assign dpos    = cfg_t1 ? bit_pos - 1'b1 : bit_pos;
   assign sh_next = cfg_lsb_first ? {bit_val, shreg[BYTE_W-1:1]}
                                  : {shreg[BYTE_W-2:0], bit_val};
   assign emit_fb = bit_ok & is_fbit & cfg_fbit_en;
   assign emit_d  = bit_ok & ~is_fbit & (dpos[LOW_W-1:0] == LOW_W'(BYTE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         out_valid <= 1'b0;
         out_entry <= '0;
         overflow  <= 1'b0;
      end else begin
         if (bit_ok && !is_fbit) shreg <= sh_next;
         out_valid <= emit_fb | emit_d;
         if (emit_fb) begin
            out_entry.fbit <= 1'b1;
            out_entry.slot <= '0;
            out_entry.data <= BYTE_W'(bit_val);
         end else if (emit_d) begin
            out_entry.fbit <= 1'b0;
            out_entry.slot <= dpos[LOW_W +: SLOT_W];
            out_entry.data <= sh_next;
         end
         if (out_valid && !out_ready) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
   import tdm_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OFS_W       = 8,
   parameter int T1_BITS     = 193,
   parameter int E1_BITS     = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_sync,
   input  logic             ser_data,
   input  logic             cfg_t1,
   input  logic             cfg_fbit_en,
   input  logic             cfg_sync_fall,
   input  logic             cfg_data_fall,
   input  logic             cfg_sync_low,
   input  logic             cfg_lsb_first,
   input  logic             cfg_invert,
   input  logic [OFS_W-1:0] cfg_offset,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic [4:0]       out_slot,
   output logic             out_fbit,
   output logic             overflow,
   output logic             resync_err
);
   localparam int POS_W = $clog2(E1_BITS);

   if (E1_BITS != 32 * BYTE_W) begin : g_bad_e1
      $error("tdm_frame_rx: E1_BITS must hold 32 byte slots");
   end

   logic             c_rise, c_fall, s_sync, s_data;
   logic             bit_ok;
   logic [POS_W-1:0] bit_pos;
   rx_entry_t        entry;

   tdm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_clk (ser_clk),
      .line_sync(ser_sync),
      .line_data(ser_data),
      .clk_rise (c_rise),
      .clk_fall (c_fall),
      .sync_q   (s_sync),
      .data_q   (s_data)
   );

   tdm_rx_align #(.OFS_W(OFS_W), .T1_BITS(T1_BITS), .E1_BITS(E1_BITS)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_evt  (cfg_sync_fall ? c_fall : c_rise),
      .sync_act  (s_sync ^ cfg_sync_low),
      .data_evt  (cfg_data_fall ? c_fall : c_rise),
      .cfg_t1    (cfg_t1),
      .cfg_offset(cfg_offset),
      .bit_ok    (bit_ok),
      .bit_pos   (bit_pos),
      .resync_err(resync_err)
   );

   tdm_rx_pack #(.POS_W(POS_W)) u_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_ok       (bit_ok),
      .bit_pos      (bit_pos),
      .bit_val      (s_data ^ cfg_invert),
      .cfg_t1       (cfg_t1),
      .cfg_fbit_en  (cfg_fbit_en),
      .cfg_lsb_first(cfg_lsb_first),
      .out_ready    (out_ready),
      .out_valid    (out_valid),
      .out_entry    (entry),
      .overflow     (overflow)
   );

   assign out_data = entry.data;
   assign out_slot = entry.slot;
   assign out_fbit = entry.fbit;
endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_t1,
   input logic       cfg_fbit_en,
   input logic       out_ready,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic [4:0] out_slot,
   input logic       out_fbit,
   input logic       overflow,
   input logic       resync_err
);
   assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cfg_t1 |-> out_slot < 5'd24);

   assert_fbit_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_fbit |-> cfg_t1 && cfg_fbit_en && out_slot == 5'd0 && out_data[7:1] == 7'd0);

   assert_no_fbit_e1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !cfg_t1 |-> !out_fbit);

   assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_overflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> overflow);

   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_resync_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resync_err |=> !resync_err);
endmodule

bind tdm_frame_rx tdm_frame_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_t1     (cfg_t1),
   .cfg_fbit_en(cfg_fbit_en),
   .out_ready  (out_ready),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .out_slot   (out_slot),
   .out_fbit   (out_fbit),
   .overflow   (overflow),
   .resync_err (resync_err)
);

// File: tb/tdm_frame_rx_bench.sv
`timescale 1ns/1ps
module tdm_frame_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_sync = 1'b0, ser_data = 1'b1;
   logic       cfg_t1 = 1'b1, cfg_fbit_en = 1'b1, cfg_sync_fall = 1'b0, cfg_data_fall = 1'b0;
   logic       cfg_sync_low = 1'b0, cfg_lsb_first = 1'b0, cfg_invert = 1'b0;
   logic [7:0] cfg_offset = '0;
   logic       out_ready = 1'b1;
   logic       out_valid, out_fbit, overflow, resync_err;
   logic [7:0] out_data;
   logic [4:0] out_slot;

   always #10 clk = ~clk;

   tdm_frame_rx u_tdm_frame_rx (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
      .cfg_t1(cfg_t1), .cfg_fbit_en(cfg_fbit_en), .cfg_sync_fall(cfg_sync_fall),
      .cfg_data_fall(cfg_data_fall), .cfg_sync_low(cfg_sync_low), .cfg_lsb_first(cfg_lsb_first),
      .cfg_invert(cfg_invert), .cfg_offset(cfg_offset), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot), .out_fbit(out_fbit),
      .overflow(overflow), .resync_err(resync_err)
   );

   int n_chk = 0, n_bad = 0;

   // line stream and expected bytes
   logic ln [0:4095];
   logic sy [0:4095];
   int   nbits;
   logic [7:0] e_data [0:255];
   logic [4:0] e_slot [0:255];
   logic       e_fb   [0:255];
   int   n_exp;

   // observed bytes
   logic [7:0] g_data [0:255];
   logic [4:0] g_slot [0:255];
   logic       g_fb   [0:255];
   int   n_got = 0, n_resync = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready && n_got < 256) begin
            g_data[n_got] = out_data;
            g_slot[n_got] = out_slot;
            g_fb[n_got]   = out_fbit;
            n_got++;
         end
         if (resync_err) n_resync++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ser_clk = 1'b0;
      ser_sync = cfg_sync_low;
      ser_data = 1'b1;
      out_ready = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_got = 0;
      n_resync = 0;
      nbits = 0;
      n_exp = 0;
      for (int i = 0; i < 4096; i++) sy[i] = 1'b0;
   endtask

   function automatic logic [7:0] byte_val(input int f, input int s);
      return 8'((f * 37 + s * 11 + 5) ^ (s << 4));
   endfunction

   function automatic int lead_len();
      return int'(cfg_offset) + ((cfg_sync_fall && !cfg_data_fall) ? 1 : 0);
   endfunction

   task automatic add_idle(input int n);
      for (int i = 0; i < n; i++) begin
         ln[nbits] = 1'b1;
         nbits++;
      end
   endtask

   task automatic add_exp(input logic [7:0] d, input logic [4:0] s, input logic fb);
      e_data[n_exp] = d;
      e_slot[n_exp] = s;
      e_fb[n_exp]   = fb;
      n_exp++;
   endtask

   task automatic add_frame(input int f, input bit with_sync);
      logic [7:0] v;
      logic       fb;
      if (with_sync) sy[nbits - lead_len()] = 1'b1;
      if (cfg_t1) begin
         fb = f[0];
         ln[nbits] = fb ^ cfg_invert;
         nbits++;
         if (cfg_fbit_en) add_exp({7'd0, fb}, 5'd0, 1'b1);
      end
      for (int s = 0; s < (cfg_t1 ? 24 : 32); s++) begin
         v = byte_val(f, s);
         add_exp(v, 5'(s), 1'b0);
         for (int i = 0; i < 8; i++) begin
            ln[nbits] = (cfg_lsb_first ? v[i] : v[7-i]) ^ cfg_invert;
            nbits++;
         end
      end
   endtask

   task automatic play();
      logic act;
      for (int p = 0; p < nbits; p++) begin
         act = sy[p] ? ~cfg_sync_low : cfg_sync_low;
         if (!cfg_data_fall) ser_data = ln[p];
         if (!cfg_sync_fall) ser_sync = act;
         repeat (2) @(negedge clk);
         ser_clk = 1'b1;
         repeat (2) @(negedge clk);
         if (cfg_data_fall) ser_data = ln[p];
         if (cfg_sync_fall) ser_sync = act;
         repeat (2) @(negedge clk);
         ser_clk = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic compare(input string req, input int first);
      check(n_got == n_exp, {req, " byte count"}, n_got, n_exp);
      for (int i = first; i < n_exp && i < n_got; i++) begin
         check(g_data[i] == e_data[i], {req, " data"}, g_data[i], e_data[i]);
         check(g_slot[i] == e_slot[i], {req, " slot"}, g_slot[i], e_slot[i]);
         check(g_fb[i] == e_fb[i], {req, " fbit flag"}, g_fb[i], e_fb[i]);
      end
   endtask

   task automatic set_cfg(input bit t1, input bit fbe, input bit sf, input bit df,
                          input bit sl, input bit lsb, input bit inv, input int ofs);
      cfg_t1 = t1; cfg_fbit_en = fbe; cfg_sync_fall = sf; cfg_data_fall = df;
      cfg_sync_low = sl; cfg_lsb_first = lsb; cfg_invert = inv; cfg_offset = 8'(ofs);
   endtask

   task automatic t_reset_state();
      set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R12 out_valid in reset", out_valid, 0);
      check(overflow == 1'b0, "R12 overflow in reset", overflow, 0);
      check(resync_err == 1'b0, "R12 resync_err in reset", resync_err, 0);
      do_reset();
      check(out_valid == 1'b0 && overflow == 1'b0, "R12 after reset", {out_valid, overflow}, 0);
   endtask

   task automatic t_no_sync_R11();
      set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
      do_reset();
      for (int i = 0; i < 60; i++) begin
         ln[nbits] = 1'(i % 3);
         nbits++;
      end
      play();
      check(n_got == 0, "R11 bytes before sync", n_got, 0);
   endtask

   task automatic t_t1_fbit_R1_R2();
      set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(0, 1);
      add_frame(1, 1);
      play();
      compare("R1 R2 T1 framing byte msb", 0);
      check(n_resync == 0, "R10 no error on aligned syncs", n_resync, 0);
   endtask

   task automatic t_t1_nofbit_R7_R8_R4();
      set_cfg(1, 0, 0, 0, 0, 1, 1, 3);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(2, 1);
      add_frame(3, 1);
      play();
      compare("R2 R4 R7 R8 T1 no fbit lsb invert offset3", 0);
   endtask

   task automatic t_e1_syncfall_low_R3_R5_R6();
      set_cfg(0, 1, 1, 0, 1, 0, 0, 2);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(4, 1);
      add_frame(5, 1);
      play();
      compare("R3 R5 R6 E1 sync fall active low offset2", 0);
   endtask

   task automatic t_e1_datafall_R6();
      set_cfg(0, 0, 0, 1, 0, 1, 0, 0);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(6, 1);
      play();
      compare("R6 E1 data fall", 0);
   endtask

   task automatic t_overflow_R9();
      set_cfg(0, 0, 0, 0, 0, 0, 0, 1);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(7, 1);
      out_ready = 1'b0;
      play();
      check(n_got == 0, "R9 bytes accepted with ready low", n_got, 0);
      check(overflow == 1'b1, "R9 overflow set", overflow, 1);
      out_ready = 1'b1;
      repeat (20) @(negedge clk);
      check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
      do_reset();
      check(overflow == 1'b0, "R12 overflow cleared by reset", overflow, 0);
   endtask

   task automatic t_resync_R10();
      set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
      do_reset();
      add_idle(lead_len() + 2);
      add_frame(8, 1);
      for (int i = 0; i < 13; i++) begin
         ln[nbits] = 1'b0;
         nbits++;
      end
      add_exp(8'h00, 5'd0, 1'b1);
      add_exp(8'h00, 5'd0, 1'b0);
      add_frame(9, 1);
      play();
      check(n_resync == 1, "R10 resync pulses", n_resync, 1);
      compare("R10 realigned frame", 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_no_sync_R11();
      t_t1_fbit_R1_R2();
      t_t1_nofbit_R7_R8_R4();
      t_e1_syncfall_low_R3_R5_R6();
      t_e1_datafall_R6();
      t_overflow_R9();
      t_resync_R10();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule